// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Controller

This block is the control unit for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory access and writeback. On every cycle it compares the source register indices of the instruction in execute against the destination indices held by the two older instructions in the memory and writeback stages. It then drives one operand-bypass select per source, so that a value not yet written to the register file replaces the stale read.

The same block watches the decode stage for a load-use dependency and answers with a one-cycle stall. It also takes the branch and jump outcome resolved in execute. A taken transfer loads the PC from the target computed in execute. It also squashes the two younger instructions: the fetch slot is cleared as it enters the fetch/decode register, and the decode slot becomes a bubble as it enters the decode/execute register.

The ALU, the register file, the decoder and the memories sit outside this block. The pipeline feeds it the indices and the control bits, and it returns the mux selects and the hold and flush controls. Instructions that read no register, such as upper-immediate forms, present source index zero.

Top module: `pipe_hazard_unit`

## Requirements
- R1: A source in execute with no live match in either older stage gets bypass code 2'b00, which selects the register-file read.
- R2: A source equal to the memory-stage destination, with the memory-stage write enable high, gets code 2'b10 (memory-stage value).
- R3: A source equal to the writeback destination, with the writeback write enable high and no live memory-stage match, gets code 2'b01 (writeback value).
- R4: When the memory and writeback stages both match a source and both write, the code is 2'b10: the newer value wins.
- R5: A stage whose write enable is low never supplies a bypass, even when its destination index matches.
- R6: Register index zero is never bypassed, and a load whose destination is zero never stalls the pipeline.
- R7: A load in execute whose nonzero destination equals either source of the instruction in decode yields pc_sel 2'b01 (hold), ifid_hold 1, idex_bubble 1 and ifid_flush 0 for that cycle.
- R8: A matching destination in execute that does not belong to a load causes no stall: pc_sel stays 2'b00 and ifid_hold stays 0.
- R9: A taken branch or a jump in execute yields pc_sel 2'b10 (target), ifid_flush 1 and idex_bubble 1.
- R10: When a redirect and a load-use stall occur in the same cycle, the redirect wins: pc_sel 2'b10, ifid_hold 0, ifid_flush 1, idex_bubble 1.
- R11: With no hazard and no redirect, pc_sel is 2'b00 and ifid_hold, ifid_flush and idex_bubble are all 0.
- R12: Each source is resolved on its own, so one instruction can take one operand from the memory stage and the other from writeback in the same cycle. Source s occupies bits [2s+1:2s] of fwd_sel and bits [5s+4:5s] of the index buses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset; disables the property checks |
| ex_src_idx | input | NUM_SRC*REG_IDX_W | Source register indices of the instruction in execute |
| id_src_idx | input | NUM_SRC*REG_IDX_W | Source register indices of the instruction in decode |
| ex_dst_idx | input | REG_IDX_W | Destination index of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_dst_idx | input | REG_IDX_W | Destination index held in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst_idx | input | REG_IDX_W | Destination index held in the writeback stage |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| ex_branch_taken | input | 1 | Conditional branch in execute resolved taken |
| ex_is_jump | input | 1 | Unconditional jump in execute |
| fwd_sel | output | 2*NUM_SRC | Bypass code per execute source (00 file, 01 writeback, 10 memory) |
| pc_sel | output | 2 | Next-PC choice (00 sequential, 01 hold, 10 execute target) |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The hardest situation is a load-use stall that meets a taken redirect in the same cycle. A real pipeline cannot reach it, because a load and a branch never share the execute stage. The bench drives the stage controls directly, so it raises the load flag and the branch outcome together and checks that the redirect outputs win. It also sets up instructions whose two operands bypass from different stages at once, and destinations that match while the write enable is low.

// File: rtl/pipe_hazard_pkg.sv
`timescale 1ns/1ps
package pipe_hazard_pkg;

   // Operand bypass choice for one source in the execute stage
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_src_e;

   // Next-PC choice handed to the fetch stage
   typedef enum logic [1:0] {
      PC_SEQ    = 2'b00,
      PC_HOLD   = 2'b01,
      PC_TARGET = 2'b10
   } pc_sel_e;

endpackage

// File: rtl/hz_fwd_pick.sv
`timescale 1ns/1ps
// Bypass selection for a single execute-stage source operand.
module hz_fwd_pick
   import pipe_hazard_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] mem_dst,
   input  logic             mem_we,
   input  logic [IDX_W-1:0] wb_dst,
   input  logic             wb_we,
   output logic [1:0]       sel
);

   localparam logic [IDX_W-1:0] IDX_ZERO = '0;

   logic src_live;
   logic hit_mem;
   logic hit_wb;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign src_live = (src_idx != IDX_ZERO);
      end else begin : g_zero_soft
         assign src_live = 1'b1;
      end
   endgenerate

   assign hit_mem = src_live & mem_we & (mem_dst == src_idx);
   assign hit_wb  = src_live & wb_we  & (wb_dst  == src_idx);

   // The memory stage holds the younger producer, so it is tested first
   always_comb begin
      sel = FWD_RF;
      if (hit_mem) begin
         sel = FWD_MEM;
      end else if (hit_wb) begin
         sel = FWD_WB;
      end
   end

endmodule

// File: rtl/hz_load_use.sv
`timescale 1ns/1ps
// Detects a decode-stage read of a register that a load in execute will write.
module hz_load_use #(
   parameter int IDX_W     = 5,
   parameter int NUM_SRC   = 2,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic                     ex_is_load,
   input  logic [IDX_W-1:0]         ex_dst,
   input  logic [NUM_SRC*IDX_W-1:0] id_src,
   output logic                     load_use
);

   localparam logic [IDX_W-1:0] IDX_ZERO = '0;

   logic [NUM_SRC-1:0] src_hit;
   logic               dst_live;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign dst_live = (ex_dst != IDX_ZERO);
      end else begin : g_zero_soft
         assign dst_live = 1'b1;
      end

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign src_hit[s] = (id_src[s*IDX_W +: IDX_W] == ex_dst);
      end
   endgenerate

   assign load_use = ex_is_load & dst_live & (|src_hit);

endmodule

// File: rtl/hz_redirect.sv
`timescale 1ns/1ps
// Arbitrates redirect against stall and drives PC choice and stage controls.
module hz_redirect
   import pipe_hazard_pkg::*;
(
   input  logic       branch_taken,
   input  logic       is_jump,
   input  logic       load_use,
   output logic [1:0] pc_sel,
   output logic       ifid_hold,
   output logic       ifid_flush,
   output logic       idex_bubble
);

   logic redirect;

   assign redirect = branch_taken | is_jump;

   always_comb begin
      pc_sel      = PC_SEQ;
      ifid_hold   = 1'b0;
      ifid_flush  = 1'b0;
      idex_bubble = 1'b0;
      if (redirect) begin
         // Squash the two younger instructions and steer fetch to the target
         pc_sel      = PC_TARGET;
         ifid_flush  = 1'b1;
         idex_bubble = 1'b1;
      end else if (load_use) begin
         // Freeze fetch and decode one cycle while execute receives a bubble
         pc_sel      = PC_HOLD;
         ifid_hold   = 1'b1;
         idex_bubble = 1'b1;
      end
   end

endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
module pipe_hazard_unit
   import pipe_hazard_pkg::*;
#(
   parameter int REG_IDX_W          = 5,
   parameter int NUM_SRC            = 2,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_SRC*REG_IDX_W-1:0] ex_src_idx,
   input  logic [NUM_SRC*REG_IDX_W-1:0] id_src_idx,
   input  logic [REG_IDX_W-1:0]         ex_dst_idx,
   input  logic                         ex_is_load,
   input  logic [REG_IDX_W-1:0]         mem_dst_idx,
   input  logic                         mem_wr_en,
   input  logic [REG_IDX_W-1:0]         wb_dst_idx,
   input  logic                         wb_wr_en,
   input  logic                         ex_branch_taken,
   input  logic                         ex_is_jump,
   output logic [2*NUM_SRC-1:0]         fwd_sel,
   output logic [1:0]                   pc_sel,
   output logic                         ifid_hold,
   output logic                         ifid_flush,
   output logic                         idex_bubble
);

   localparam int SEL_W = 2;
   localparam logic [REG_IDX_W-1:0] IDX_ZERO = '0;

   initial begin : p_param_check
      if (REG_IDX_W < 1 || REG_IDX_W > 8)
         $fatal(1, "REG_IDX_W must lie in 1..8");
      if (NUM_SRC < 1 || NUM_SRC > 4)
         $fatal(1, "NUM_SRC must lie in 1..4");
   end

   logic load_use;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_fwd
         hz_fwd_pick #(
            .IDX_W     (REG_IDX_W),
            .ZERO_HARD (ZERO_REG_HARDWIRED)
         ) u_pick (
            .src_idx (ex_src_idx[s*REG_IDX_W +: REG_IDX_W]),
            .mem_dst (mem_dst_idx),
            .mem_we  (mem_wr_en),
            .wb_dst  (wb_dst_idx),
            .wb_we   (wb_wr_en),
            .sel     (fwd_sel[s*SEL_W +: SEL_W])
         );

         // R4 / R2: a live memory-stage match always selects the memory value
         a_r4_mem_priority: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_src_idx[s*REG_IDX_W +: REG_IDX_W] != IDX_ZERO && mem_wr_en &&
             mem_dst_idx == ex_src_idx[s*REG_IDX_W +: REG_IDX_W])
            |-> fwd_sel[s*SEL_W +: SEL_W] == FWD_MEM);

         // R5: without any write enable nothing is bypassed
         a_r5_no_wen_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            (!mem_wr_en && !wb_wr_en) |-> fwd_sel[s*SEL_W +: SEL_W] == FWD_RF);

         if (ZERO_REG_HARDWIRED) begin : g_zero_chk
            // R6: index zero reads the register file
            a_r6_zero_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
               (ex_src_idx[s*REG_IDX_W +: REG_IDX_W] == IDX_ZERO)
               |-> fwd_sel[s*SEL_W +: SEL_W] == FWD_RF);
         end
      end
   endgenerate

   hz_load_use #(
      .IDX_W     (REG_IDX_W),
      .NUM_SRC   (NUM_SRC),
      .ZERO_HARD (ZERO_REG_HARDWIRED)
   ) u_load_use (
      .ex_is_load (ex_is_load),
      .ex_dst     (ex_dst_idx),
      .id_src     (id_src_idx),
      .load_use   (load_use)
   );

   hz_redirect u_redirect (
      .branch_taken (ex_branch_taken),
      .is_jump      (ex_is_jump),
      .load_use     (load_use),
      .pc_sel       (pc_sel),
      .ifid_hold    (ifid_hold),
      .ifid_flush   (ifid_flush),
      .idex_bubble  (idex_bubble)
   );

   // R9 / R10: a redirect squashes both younger slots and never holds
   a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_branch_taken || ex_is_jump)
      |-> (pc_sel == PC_TARGET && ifid_flush && idex_bubble && !ifid_hold));

   // R7: a hold always comes with a bubble and a frozen PC
   a_r7_hold_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_hold |-> (pc_sel == PC_HOLD && idex_bubble && !ifid_flush));

   // R8: without a load in execute nothing holds
   a_r8_no_load_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> !ifid_hold);

   // R11: quiet controls keep the pipeline streaming
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_is_load && !ex_branch_taken && !ex_is_jump)
      |-> (pc_sel == PC_SEQ && !ifid_flush && !idex_bubble));

endmodule

// File: tb/pipe_hazard_unit_bench.sv
`timescale 1ns/1ps
module pipe_hazard_unit_bench;

   localparam int W  = 5;
   localparam int NS = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS*W-1:0] ex_src_idx, id_src_idx;
   logic [W-1:0]    ex_dst_idx, mem_dst_idx, wb_dst_idx;
   logic            ex_is_load, mem_wr_en, wb_wr_en;
   logic            ex_branch_taken, ex_is_jump;
   logic [2*NS-1:0] fwd_sel;
   logic [1:0]      pc_sel;
   logic            ifid_hold, ifid_flush, idex_bubble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pipe_hazard_unit u_pipe_hazard_unit (
      .clk(clk), .rst_n(rst_n),
      .ex_src_idx(ex_src_idx), .id_src_idx(id_src_idx),
      .ex_dst_idx(ex_dst_idx), .ex_is_load(ex_is_load),
      .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en),
      .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en),
      .ex_branch_taken(ex_branch_taken), .ex_is_jump(ex_is_jump),
      .fwd_sel(fwd_sel), .pc_sel(pc_sel),
      .ifid_hold(ifid_hold), .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic quiet();
      @(negedge clk);
      ex_src_idx = '0; id_src_idx = '0;
      ex_dst_idx = '0; mem_dst_idx = '0; wb_dst_idx = '0;
      ex_is_load = 1'b0; mem_wr_en = 1'b0; wb_wr_en = 1'b0;
      ex_branch_taken = 1'b0; ex_is_jump = 1'b0;
   endtask

   // Control outputs packed as {pc_sel, hold, flush, bubble}
   function automatic int ctl();
      return {pc_sel, ifid_hold, ifid_flush, idex_bubble};
   endfunction

   task automatic settle();
      #1;
   endtask

   task automatic t_no_match();
      quiet();
      ex_src_idx = {5'd3, 5'd4}; mem_dst_idx = 5'd7; mem_wr_en = 1'b1;
      wb_dst_idx = 5'd8; wb_wr_en = 1'b1;
      settle();
      check("R1 src0 no match", fwd_sel[1:0], 0);
      check("R1 src1 no match", fwd_sel[3:2], 0);
   endtask

   task automatic t_mem_fwd();
      quiet();
      ex_src_idx = {5'd0, 5'd10}; mem_dst_idx = 5'd10; mem_wr_en = 1'b1;
      settle();
      check("R2 mem bypass", fwd_sel[1:0], 2);
   endtask

   task automatic t_wb_fwd();
      quiet();
      ex_src_idx = {5'd12, 5'd0}; wb_dst_idx = 5'd12; wb_wr_en = 1'b1;
      mem_dst_idx = 5'd13; mem_wr_en = 1'b1;
      settle();
      check("R3 wb bypass", fwd_sel[3:2], 1);
   endtask

   task automatic t_both_match();
      quiet();
      ex_src_idx = {5'd9, 5'd9}; mem_dst_idx = 5'd9; wb_dst_idx = 5'd9;
      mem_wr_en = 1'b1; wb_wr_en = 1'b1;
      settle();
      check("R4 mem wins src0", fwd_sel[1:0], 2);
      check("R4 mem wins src1", fwd_sel[3:2], 2);
   endtask

   task automatic t_wen_low();
      quiet();
      ex_src_idx = {5'd5, 5'd5}; mem_dst_idx = 5'd5; wb_dst_idx = 5'd5;
      settle();
      check("R5 both enables low", fwd_sel, 0);
      mem_wr_en = 1'b0; wb_wr_en = 1'b1;
      settle();
      check("R5 mem enable low falls to wb", fwd_sel[1:0], 1);
   endtask

   task automatic t_zero();
      quiet();
      ex_src_idx = '0; mem_wr_en = 1'b1; wb_wr_en = 1'b1;
      settle();
      check("R6 zero index not bypassed", fwd_sel, 0);
      ex_is_load = 1'b1; ex_dst_idx = '0; id_src_idx = '0;
      settle();
      check("R6 zero load no stall", ctl(), 0);
   endtask

   task automatic t_load_use();
      quiet();
      ex_is_load = 1'b1; ex_dst_idx = 5'd17; id_src_idx = {5'd2, 5'd17};
      settle();
      check("R7 load-use src0", ctl(), 5'b01101);
      id_src_idx = {5'd17, 5'd2};
      settle();
      check("R7 load-use src1", ctl(), 5'b01101);
      id_src_idx = {5'd3, 5'd2};
      settle();
      check("R7 load no dependence", ctl(), 0);
   endtask

   task automatic t_non_load();
      quiet();
      ex_dst_idx = 5'd17; id_src_idx = {5'd2, 5'd17};
      settle();
      check("R8 alu result no stall", ctl(), 0);
   endtask

   task automatic t_redirect();
      quiet();
      ex_branch_taken = 1'b1;
      settle();
      check("R9 taken branch", ctl(), 5'b10011);
      ex_branch_taken = 1'b0; ex_is_jump = 1'b1;
      settle();
      check("R9 jump", ctl(), 5'b10011);
   endtask

   task automatic t_flush_over_stall();
      quiet();
      ex_is_load = 1'b1; ex_dst_idx = 5'd6; id_src_idx = {5'd6, 5'd6};
      ex_branch_taken = 1'b1;
      settle();
      check("R10 flush beats stall", ctl(), 5'b10011);
   endtask

   task automatic t_idle();
      quiet();
      settle();
      check("R11 idle controls", ctl(), 0);
   endtask

   task automatic t_split_sources();
      quiet();
      ex_src_idx = {5'd21, 5'd20}; mem_dst_idx = 5'd20; wb_dst_idx = 5'd21;
      mem_wr_en = 1'b1; wb_wr_en = 1'b1;
      settle();
      check("R12 src0 from mem", fwd_sel[1:0], 2);
      check("R12 src1 from wb", fwd_sel[3:2], 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      quiet();
      repeat (3) @(negedge clk);
      settle();
      check("R11 reset state controls", ctl(), 0);
      check("R1 reset state bypass", fwd_sel, 0);
      rst_n = 1'b1;
      t_idle();
      t_no_match();
      t_mem_fwd();
      t_wb_fwd();
      t_both_match();
      t_wen_low();
      t_zero();
      t_load_use();
      t_non_load();
      t_redirect();
      t_flush_over_stall();
      t_split_sources();
      quiet();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule